// File: doc/BRIEF.md
# Flow-Gated Serial Byte Transmitter

This block turns queued bytes into asynchronous serial frames on a single output line. Bytes are written into a 16-entry queue. A frame engine then sends each byte as a low start bit, eight data bits with the least significant bit first, and a high stop bit. An external single-cycle `bit_tick` pulse marks every bit period, so each bit lasts exactly one tick interval. The block does not generate the baud rate itself.

When `flow_en` is set, the active-low `cts_n` input decides whether a new character may begin. `cts_n` passes through a two-stage synchronizer. It is looked at only on the tick that would launch a frame: either from idle, or at the end of a stop bit. A frame that has already started therefore always finishes. While sending is held off, the line rests at logic 1. The next queued byte goes out as soon as `cts_n` is driven low again. When `flow_en` is clear, `cts_n` is ignored and the queue drains freely. The block has no interrupt output, so a change on `cts_n` cannot raise an interrupt request.

Top module: `uart_cts_tx`

## Requirements
- R1: Each frame is one start bit (0), eight data bits sent LSB first, and one stop bit (1). Every bit lasts exactly one `bit_tick` interval, and a frame begins on the clock after a tick.
- R2: With no frame in progress, `txd` is 1 and `tx_busy` is 0. This is also the state after reset.
- R3: The queue holds 16 bytes and sends them in write order. `fifo_empty` is 1 when it holds none and `fifo_full` is 1 when it holds 16. After reset the queue is empty and not full.
- R4: A write while `fifo_full` is 1 is discarded. `wr_drop` is 1 in that same cycle. The queued contents are unchanged.
- R5: With `flow_en`=1 and `cts_n`=1 (deasserted), no new frame starts. `txd` stays 1, `tx_busy` stays 0, and queued bytes remain queued.
- R6: If `cts_n` goes high during a frame, that frame completes in full before sending stops.
- R7: When `cts_n` returns low with `flow_en`=1, the next queued byte is sent, starting with its start bit.
- R8: With `flow_en`=0, the level on `cts_n` has no effect and queued bytes are sent.
- R9: `tx_busy` is 1 from the start bit through the end of the stop bit. While sending is allowed and data is queued, frames follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| flow_en | input | 1 | Enables hardware clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output line |
| tx_busy | output | 1 | A frame is on the line |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds 16 bytes |
| wr_drop | output | 1 | Current write discarded because the queue is full |

## Verification
The hardest case to reach is a `cts_n` deassertion that lands inside a frame while a second byte is already waiting. To get there, the bench queues two bytes with `cts_n` low and waits for `tx_busy` to rise. It then raises `cts_n` during the start bit. From that point it checks three things: the first frame arrives intact, the line then stays high with the queue still non-empty, and the second byte appears only after `cts_n` falls again. Overflow is reached by filling the queue while it is held off, so that nothing drains during the seventeenth write.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
    localparam int DATA_W = 8;
    localparam int BIT_CW = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        tx_state_e          state;
        logic [DATA_W-1:0]  shreg;
        logic [BIT_CW-1:0]  bitcnt;
        logic               txd;
    } ser_reg_t;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Reset to 1: clear-to-send counts as deasserted until a real level arrives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_reg_t;

    fifo_reg_t    r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_wr, do_rd;

    assign empty   = (r_q.cnt == '0);
    assign full    = (r_q.cnt == CW'(DEPTH));
    assign dropped = push && full;
    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign head    = mem_q[r_q.rptr];

    always_comb begin
        r_d = r_q;
        if (do_wr) r_d.wptr = (r_q.wptr == AW'(DEPTH-1)) ? '0 : r_q.wptr + 1'b1;
        if (do_rd) r_d.rptr = (r_q.rptr == AW'(DEPTH-1)) ? '0 : r_q.rptr + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[r_q.wptr] <= push_data;
    end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import uart_cts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              may_send,
    input  logic              have_data,
    input  logic [DATA_W-1:0] head_data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DATA_W - 1);

    ser_reg_t s_q, s_d;
    logic     launch_ok;

    // Permission is consulted only on launch ticks: from idle or at the end of a stop bit.
    assign launch_ok = have_data && may_send;

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (bit_tick && launch_ok) begin
                    s_d.state = ST_START;
                    s_d.txd   = 1'b0;
                    s_d.shreg = head_data;
                    pop       = 1'b1;
                end
            end
            ST_START: begin
                if (bit_tick) begin
                    s_d.state  = ST_DATA;
                    s_d.txd    = s_q.shreg[0];
                    s_d.shreg  = s_q.shreg >> 1;
                    s_d.bitcnt = '0;
                end
            end
            ST_DATA: begin
                if (bit_tick) begin
                    if (s_q.bitcnt == LAST_BIT) begin
                        s_d.state = ST_STOP;
                        s_d.txd   = 1'b1;
                    end else begin
                        s_d.txd    = s_q.shreg[0];
                        s_d.shreg  = s_q.shreg >> 1;
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (bit_tick) begin
                    if (launch_ok) begin
                        s_d.state = ST_START;
                        s_d.txd   = 1'b0;
                        s_d.shreg = head_data;
                        pop       = 1'b1;
                    end else begin
                        s_d.state = ST_IDLE;
                        s_d.txd   = 1'b1;
                    end
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.txd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.txd;
    assign busy = (s_q.state != ST_IDLE);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_cts_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flow_en,
    input  logic              cts_n,
    input  logic              bit_tick,
    output logic              txd,
    output logic              tx_busy,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              wr_drop
);
    logic              cts_n_sync;
    logic              may_send;
    logic              pop;
    logic [DATA_W-1:0] head;

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_n),
        .sync_out (cts_n_sync)
    );

    tx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .dropped   (wr_drop)
    );

    // Without flow control the clear-to-send level is ignored.
    assign may_send = !flow_en || !cts_n_sync;

    tx_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .may_send  (may_send),
        .have_data (!fifo_empty),
        .head_data (head),
        .pop       (pop),
        .txd       (txd),
        .busy      (tx_busy)
    );
endmodule

// File: rtl/uart_cts_tx_checker.sv
module uart_cts_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic flow_en,
    input logic cts_n,
    input logic txd,
    input logic tx_busy,
    input logic fifo_empty,
    input logic fifo_full,
    input logic wr_drop
);
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_busy_starts_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    p_status_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    p_drop_only_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> (fifo_full && wr_en));

    p_full_write_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full) |-> wr_drop);

    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && flow_en && cts_n && $past(cts_n) && $past(cts_n, 2))
        |=> !tx_busy);

    p_stays_queued_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !fifo_empty && !wr_en && flow_en && cts_n
         && $past(cts_n) && $past(cts_n, 2)) |=> !fifo_empty);
endmodule

bind uart_cts_tx uart_cts_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .flow_en    (flow_en),
    .cts_n      (cts_n),
    .txd        (txd),
    .tx_busy    (tx_busy),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .wr_drop    (wr_drop)
);

// File: tb/uart_cts_tx_test.sv
`timescale 1ns/1ps
module uart_cts_tx_test;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flow_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       bit_tick = 1'b0;
    logic       txd, tx_busy, fifo_empty, fifo_full, wr_drop;

    int errors = 0;
    int checks = 0;
    int nframes = 0;
    int cyc = 0;
    int tick_cnt = 0;
    logic [7:0] exp_q [$];

    always #5 clk = ~clk;

    uart_cts_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flow_en(flow_en), .cts_n(cts_n), .bit_tick(bit_tick),
        .txd(txd), .tx_busy(tx_busy), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .wr_drop(wr_drop)
    );

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
        bit_tick <= (tick_cnt == TICK_DIV-1);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit expect_sent);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        if (expect_sent) exp_q.push_back(b);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !tx_busy && fifo_empty) break;
        end
    endtask

    // Monitor: rebuild frames from the line and compare against the scoreboard queue.
    initial begin
        logic [7:0] got;
        logic       start_ok, stop_ok, busy_ok;
        forever begin
            @(negedge clk);
            if (rst_n && !txd) begin
                repeat (2) @(negedge clk);
                start_ok = !txd;
                busy_ok  = tx_busy;
                for (int b = 0; b < 8; b++) begin
                    repeat (TICK_DIV) @(negedge clk);
                    got[b]  = txd;
                    busy_ok = busy_ok && tx_busy;
                end
                repeat (TICK_DIV) @(negedge clk);
                stop_ok = txd;
                busy_ok = busy_ok && tx_busy;
                nframes++;
                check("R1 start bit", start_ok, 1'b1);
                check("R1 stop bit", stop_ok, 1'b1);
                check("R9 busy over frame", busy_ok, 1'b1);
                if (exp_q.size() == 0) begin
                    check("R3 unexpected frame", got, 8'hxx);
                end else begin
                    check("R1/R3 data", got, exp_q.pop_front());
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        logic saw_busy;
        repeat (5) @(negedge clk);
        // R2/R3 reset state
        check("R2 reset txd", txd, 1'b1);
        check("R2 reset busy", tx_busy, 1'b0);
        check("R3 reset empty", fifo_empty, 1'b1);
        check("R3 reset full", fifo_full, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: flow control off, cts_n high is ignored
        flow_en = 1'b0; cts_n = 1'b1;
        base = nframes;
        push(8'hA5, 1); push(8'h3C, 1); push(8'h01, 1);
        wait_drain();
        check("R8 frames sent with cts_n high", nframes - base, 3);
        check("R3 empty after drain", fifo_empty, 1'b1);

        // R5: blocked, then R7 resume
        flow_en = 1'b1; cts_n = 1'b1;
        repeat (4) @(negedge clk);
        base = nframes;
        push(8'h5A, 1); push(8'hFF, 1);
        saw_busy = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tx_busy || !txd) saw_busy = 1'b1;
        end
        check("R5 no frame while blocked", saw_busy, 1'b0);
        check("R5 bytes remain queued", fifo_empty, 1'b0);
        check("R2 idle line high", txd, 1'b1);
        @(negedge clk); cts_n = 1'b0;
        wait_drain();
        check("R7 frames after release", nframes - base, 2);

        // R6: deassert mid-frame
        base = nframes;
        push(8'h81, 1); push(8'h7E, 1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_busy) break;
        end
        cts_n = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (nframes == base + 1 && !tx_busy) break;
        end
        check("R6 first frame completed", nframes - base, 1);
        saw_busy = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tx_busy || !txd) saw_busy = 1'b1;
        end
        check("R5 stalled after frame", saw_busy, 1'b0);
        check("R5 second byte still queued", fifo_empty, 1'b0);
        cts_n = 1'b0;
        wait_drain();
        check("R7 second byte after reassert", nframes - base, 2);

        // R3/R4: fill to 16, overflow write dropped, order kept
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        base = nframes;
        for (int i = 0; i < 16; i++) push(8'(i * 17 + 3), 1);
        check("R3 full at 16", fifo_full, 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hEE;
        #1;
        check("R4 drop flagged", wr_drop, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R4 drop clears", wr_drop, 1'b0);
        check("R4 still full", fifo_full, 1'b1);
        cts_n = 1'b0;
        wait_drain();
        check("R3/R4 exactly 16 frames", nframes - base, 16);
        check("R9 back-to-back drained", fifo_empty, 1'b1);
        repeat (20) @(negedge clk);
        check("R2 idle after drain", txd, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule